// File: doc/BRIEF.md
# Sub-Pattern Clock State Generator

This block drives a bank of 48 clock lines from a table of stored sub-patterns. A sub-pattern is an ordered list of states. Each state gives the level of all 48 lines at once, a 7-bit dwell in base-clock cycles, and a tunable flag. When a state is tunable, its dwell is multiplied by a global speed factor, and a signed cycle offset is then added. When it is not, the stored dwell is used as written.

Playback is steered by dispatch words taken from an external show-ahead FIFO of 16-bit entries. Two entries make up one 32-bit word. The word names a sub-pattern and says how many times to repeat it. The generator plays that sub-pattern the requested number of times and then continues with the next word. Between words there is no gap as long as the next word is already waiting. When the FIFO runs dry, the outputs freeze on the last levels and an idle flag is raised.

State contents, sub-pattern lengths and the speed settings are loaded through plain synchronous write strobes. This is normally done before playback starts.

Top module: `subpat_clock_gen`

## Requirements
- R1: After synchronous reset, clk_out is all zero, idle is 1, fifo_rd is 0 while the FIFO is empty, the speed factor is 1 and the offset is 0.
- R2: A dispatch word is built from two FIFO entries, the first one popped giving bits [15:0] and the second giving bits [31:16]. Bits [7:0] are the sub-pattern address, of which only the low PAT_AW bits select a sub-pattern. Bits [31:8] are the repeat count, and a count of 0 plays the sub-pattern once.
- R3: A state that is not tunable holds its levels on clk_out for exactly its stored dwell in cycles. A stored dwell of 0 lasts 1 cycle.
- R4: A tunable state holds for dwell × factor + offset cycles, where the offset is signed. Any result below 1 is raised to 1.
- R5: A configuration write whose factor is 0 is ignored completely: both the factor and the offset keep their previous values.
- R6: A sub-pattern plays states 0 through its stored last index in order. With a repeat count n, it plays n times in a row with no gap.
- R7: Consecutive dispatch words play back to back with no idle cycle, provided each word is already in the FIFO and every sub-pattern has at least three states.
- R8: When the last state of the last word ends and no further word is available, idle goes to 1 and clk_out holds the final state's levels until new work arrives.
- R9: From idle with nothing buffered, the first state's levels appear on clk_out, and idle falls, at the fourth rising edge after the FIFO becomes non-empty.
- R10: fifo_rd is never asserted while fifo_empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_empty | input | 1 | Dispatch FIFO has no entry |
| fifo_data | input | 16 | Head entry of the dispatch FIFO (show-ahead) |
| fifo_rd | output | 1 | Pop the head entry at this edge |
| st_we | input | 1 | Write one state |
| st_pat | input | PAT_AW | Sub-pattern index of the state write |
| st_idx | input | STATE_AW | State index within the sub-pattern |
| st_levels | input | 48 | Levels of the 48 lines for the state |
| st_dwell | input | 7 | Reference dwell in cycles |
| st_tune | input | 1 | State dwell follows factor and offset |
| len_we | input | 1 | Write a sub-pattern length |
| len_pat | input | PAT_AW | Sub-pattern index of the length write |
| len_last | input | STATE_AW | Index of the sub-pattern's last state |
| cfg_we | input | 1 | Write speed factor and offset |
| cfg_factor | input | FACTOR_W | Global speed factor (0 rejected) |
| cfg_offset | input | OFS_W | Signed cycle offset for tunable states |
| clk_out | output | 48 | Registered clock levels |
| idle | output | 1 | No state is playing; outputs hold |

## Verification
Dispatch words are all pushed in one cycle. From that cycle the first state is due four rising edges later, so the bench samples idle on the third and fourth falling edges. After that it advances exactly one falling edge per expected cycle. For every state it compares clk_out against the levels of that state for the number of cycles that the bench computes from the stored dwell, the factor and the offset. A state that is too long or too short therefore shifts every later sample and shows up as a mismatch. Once the final expected cycle has passed, the bench checks idle and the held levels straight away, and checks them again a few cycles later.

// File: rtl/subpat_pkg.sv
package subpat_pkg;
  localparam int NCLK     = 48;   // clock lines driven
  localparam int DWELL_W  = 7;    // reference dwell width
  localparam int FIFO_W   = 16;   // dispatch FIFO entry width
  localparam int WORD_W   = 2 * FIFO_W;
  localparam int SEL_W    = 8;    // sub-pattern address field, bits [7:0]
  localparam int REP_W    = WORD_W - SEL_W; // repeat field, bits [31:8]

  typedef struct packed {
    logic               tune;
    logic [DWELL_W-1:0] dwell;
    logic [NCLK-1:0]    levels;
  } pstate_t;

  localparam int PSTATE_W = $bits(pstate_t);
endpackage

// File: rtl/subpat_ram.sv
module subpat_ram #(
  parameter int AW     = 8,
  parameter int DATA_W = 56
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/subpat_fetch.sv
module subpat_fetch import subpat_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_empty,
  input  logic [FIFO_W-1:0] fifo_data,
  output logic              fifo_rd,
  input  logic              consume,
  output logic              word_valid,
  output logic [WORD_W-1:0] word
);
  logic              have_lo;
  logic [FIFO_W-1:0] lo_half;

  assign fifo_rd = !fifo_empty && !word_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_lo    <= 1'b0;
      lo_half    <= '0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      if (consume) word_valid <= 1'b0;
      if (fifo_rd) begin
        if (!have_lo) begin
          lo_half <= fifo_data;
          have_lo <= 1'b1;
        end else begin
          word       <= {fifo_data, lo_half};
          word_valid <= 1'b1;
          have_lo    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/subpat_scale.sv
module subpat_scale import subpat_pkg::*; #(
  parameter int FACTOR_W = 4,
  parameter int OFS_W    = 8,
  parameter int CNT_W    = DWELL_W + FACTOR_W + 1
) (
  input  logic [DWELL_W-1:0]      dwell,
  input  logic                    tune,
  input  logic [FACTOR_W-1:0]     factor,
  input  logic signed [OFS_W-1:0] offset,
  output logic [CNT_W-1:0]        eff
);
  localparam int MW = DWELL_W + FACTOR_W;
  localparam int SW = CNT_W + 1;

  logic [MW-1:0]        prod;
  logic signed [SW-1:0] tuned, base;

  always_comb begin
    prod  = {{FACTOR_W{1'b0}}, dwell} * {{DWELL_W{1'b0}}, factor};
    tuned = $signed({{(SW-MW){1'b0}}, prod})
          + $signed({{(SW-OFS_W){offset[OFS_W-1]}}, offset});
    base  = tune ? tuned : $signed({{(SW-DWELL_W){1'b0}}, dwell});
    if (base[SW-1] || base == '0) eff = CNT_W'(1);
    else                          eff = base[CNT_W-1:0];
  end
endmodule

// File: rtl/subpat_clock_gen.sv
module subpat_clock_gen import subpat_pkg::*; #(
  parameter int PAT_AW   = 4,
  parameter int STATE_AW = 4,
  parameter int FACTOR_W = 4,
  parameter int OFS_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fifo_empty,
  input  logic [FIFO_W-1:0]       fifo_data,
  output logic                    fifo_rd,
  input  logic                    st_we,
  input  logic [PAT_AW-1:0]       st_pat,
  input  logic [STATE_AW-1:0]     st_idx,
  input  logic [NCLK-1:0]         st_levels,
  input  logic [DWELL_W-1:0]      st_dwell,
  input  logic                    st_tune,
  input  logic                    len_we,
  input  logic [PAT_AW-1:0]       len_pat,
  input  logic [STATE_AW-1:0]     len_last,
  input  logic                    cfg_we,
  input  logic [FACTOR_W-1:0]     cfg_factor,
  input  logic signed [OFS_W-1:0] cfg_offset,
  output logic [NCLK-1:0]         clk_out,
  output logic                    idle
);
  localparam int NPAT   = 1 << PAT_AW;
  localparam int RAM_AW = PAT_AW + STATE_AW;
  localparam int CNT_W  = DWELL_W + FACTOR_W + 1;

  // speed settings
  logic [FACTOR_W-1:0]     spd_factor;
  logic signed [OFS_W-1:0] spd_offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      spd_factor <= FACTOR_W'(1);
      spd_offset <= '0;
    end else if (cfg_we && cfg_factor != '0) begin
      spd_factor <= cfg_factor;
      spd_offset <= cfg_offset;
    end
  end

  // sub-pattern length table (last state index)
  logic [STATE_AW-1:0] len_tab [NPAT];

  always_ff @(posedge clk) begin
    if (len_we) len_tab[len_pat] <= len_last;
  end

  // dispatch word assembly
  logic              nxt_valid, take_nxt;
  logic [WORD_W-1:0] nxt_word;

  subpat_fetch u_fetch (
    .clk        (clk),
    .rst        (rst),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .fifo_rd    (fifo_rd),
    .consume    (take_nxt),
    .word_valid (nxt_valid),
    .word       (nxt_word)
  );

  // lookahead pointer: the state that plays next
  logic                la_valid, la_valid_d;
  logic [PAT_AW-1:0]   la_pat, la_pat_d;
  logic [STATE_AW-1:0] la_idx, la_idx_d;
  logic [REP_W-1:0]    la_rep, la_rep_d;

  logic             act, act_d, adv;
  logic [CNT_W-1:0] cnt, eff_dwell;
  pstate_t          wstate, q;
  logic [PSTATE_W-1:0] q_raw;

  always_comb wstate = '{tune: st_tune, dwell: st_dwell, levels: st_levels};
  assign q = pstate_t'(q_raw);

  subpat_ram #(.AW(RAM_AW), .DATA_W(PSTATE_W)) u_ram (
    .clk   (clk),
    .we    (st_we),
    .waddr ({st_pat, st_idx}),
    .wdata (wstate),
    .raddr ({la_pat_d, la_idx_d}),
    .rdata (q_raw)
  );

  subpat_scale #(.FACTOR_W(FACTOR_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_scale (
    .dwell  (q.dwell),
    .tune   (q.tune),
    .factor (spd_factor),
    .offset (spd_offset),
    .eff    (eff_dwell)
  );

  logic [PAT_AW-1:0] nxt_pat;
  logic [REP_W-1:0]  nxt_rep;

  always_comb begin
    nxt_pat    = nxt_word[PAT_AW-1:0];
    nxt_rep    = nxt_word[WORD_W-1:SEL_W];
    adv        = act ? (cnt == CNT_W'(1)) : la_valid;
    la_valid_d = la_valid;
    la_pat_d   = la_pat;
    la_idx_d   = la_idx;
    la_rep_d   = la_rep;
    take_nxt   = 1'b0;
    if (la_valid && adv) begin
      if (la_idx != len_tab[la_pat]) begin
        la_idx_d = la_idx + STATE_AW'(1);
      end else if (la_rep > REP_W'(1)) begin
        la_idx_d = '0;
        la_rep_d = la_rep - REP_W'(1);
      end else if (nxt_valid) begin
        take_nxt = 1'b1;
        la_pat_d = nxt_pat;
        la_idx_d = '0;
        la_rep_d = (nxt_rep == '0) ? REP_W'(1) : nxt_rep;
      end else begin
        la_valid_d = 1'b0;
      end
    end else if (!la_valid && nxt_valid) begin
      take_nxt   = 1'b1;
      la_valid_d = 1'b1;
      la_pat_d   = nxt_pat;
      la_idx_d   = '0;
      la_rep_d   = (nxt_rep == '0) ? REP_W'(1) : nxt_rep;
    end
    act_d = adv ? la_valid : act;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act      <= 1'b0;
      idle     <= 1'b1;
      cnt      <= '0;
      clk_out  <= '0;
      la_valid <= 1'b0;
      la_pat   <= '0;
      la_idx   <= '0;
      la_rep   <= '0;
    end else begin
      act      <= act_d;
      idle     <= !act_d;
      la_valid <= la_valid_d;
      la_pat   <= la_pat_d;
      la_idx   <= la_idx_d;
      la_rep   <= la_rep_d;
      if (adv && la_valid) begin
        clk_out <= q.levels;
        cnt     <= eff_dwell;
      end else if (act) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/subpat_clock_gen_chk.sv
module subpat_clock_gen_chk import subpat_pkg::*; #(
  parameter int CNT_W    = 12,
  parameter int FACTOR_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                fifo_empty,
  input logic                fifo_rd,
  input logic                idle,
  input logic [NCLK-1:0]     clk_out,
  input logic                act,
  input logic [CNT_W-1:0]    cnt,
  input logic [FACTOR_W-1:0] factor
);
  assert_no_pop_empty_R10: assert property (@(posedge clk) disable iff (rst)
    fifo_rd |-> !fifo_empty);

  assert_hold_while_idle_R8: assert property (@(posedge clk) disable iff (rst)
    idle |=> (!idle || $stable(clk_out)));

  assert_change_only_active_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_out) |-> !idle);

  assert_factor_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    factor != '0);

  assert_dwell_min_one_R4: assert property (@(posedge clk) disable iff (rst)
    act |-> cnt != '0);
endmodule

bind subpat_clock_gen subpat_clock_gen_chk #(.CNT_W(CNT_W), .FACTOR_W(FACTOR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fifo_empty (fifo_empty),
  .fifo_rd    (fifo_rd),
  .idle       (idle),
  .clk_out    (clk_out),
  .act        (act),
  .cnt        (cnt),
  .factor     (spd_factor)
);

// File: tb/subpat_clock_gen_bench.sv
`timescale 1ns/1ps
module subpat_clock_gen_bench;
  import subpat_pkg::*;
  localparam int PAT_AW = 4, STATE_AW = 4, FACTOR_W = 4, OFS_W = 8;
  localparam int NPAT = 1 << PAT_AW, NST = 1 << STATE_AW;

  logic clk = 1'b0, rst = 1'b1;
  logic fifo_empty, fifo_rd;
  logic [15:0] fifo_data;
  logic st_we = 0, st_tune = 0, len_we = 0, cfg_we = 0;
  logic [PAT_AW-1:0] st_pat = '0, len_pat = '0;
  logic [STATE_AW-1:0] st_idx = '0, len_last = '0;
  logic [NCLK-1:0] st_levels = '0, clk_out;
  logic [DWELL_W-1:0] st_dwell = '0;
  logic [FACTOR_W-1:0] cfg_factor = '0;
  logic signed [OFS_W-1:0] cfg_offset = '0;
  logic idle;

  always #2 clk = ~clk;

  subpat_clock_gen #(.PAT_AW(PAT_AW), .STATE_AW(STATE_AW), .FACTOR_W(FACTOR_W), .OFS_W(OFS_W))
  u_subpat_clock_gen (
    .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .st_we(st_we), .st_pat(st_pat), .st_idx(st_idx), .st_levels(st_levels), .st_dwell(st_dwell),
    .st_tune(st_tune), .len_we(len_we), .len_pat(len_pat), .len_last(len_last),
    .cfg_we(cfg_we), .cfg_factor(cfg_factor), .cfg_offset(cfg_offset),
    .clk_out(clk_out), .idle(idle));

  // show-ahead FIFO model
  logic [15:0] fifo_mem [256];
  int wr_ptr = 0, rd_ptr = 0, pop_viol = 0;
  assign fifo_empty = (rd_ptr == wr_ptr);
  assign fifo_data  = fifo_mem[rd_ptr % 256];
  always @(posedge clk) if (!rst && fifo_rd) rd_ptr <= rd_ptr + 1;
  always @(negedge clk) if (!rst && fifo_rd && fifo_empty) pop_viol++;

  int n_checks = 0, n_errs = 0;
  int wp[8], wr[8], wa[8];
  int nw = 0, cur_f = 1, cur_o = 0;

  task automatic check(bit ok, string tag, logic [63:0] actv, logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, actv, expv);
    end
  endtask

  function automatic logic [47:0] lvl(int p, int s);
    logic [15:0] a, b;
    a = 16'(p * 40503 + s * 1021);
    b = ~16'(p * 73 + s * 977);
    return {8'(p), 8'(s), a, b};
  endfunction
  function automatic int dw(int p, int s); return (p * 5 + s * 3) % 6; endfunction
  function automatic bit tn(int p, int s); return ((p + s) % 3) != 0; endfunction
  function automatic int lastix(int p); return 2 + p % 4; endfunction
  function automatic int eff(int p, int s, int f, int o);
    int v;
    v = tn(p, s) ? dw(p, s) * f + o : dw(p, s);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic push16(logic [15:0] d);
    fifo_mem[wr_ptr % 256] = d;
    wr_ptr++;
  endtask

  task automatic add_word(int addr, int rep);
    logic [31:0] w;
    w = {24'(rep), 8'(addr)};
    wa[nw] = addr; wp[nw] = addr % NPAT; wr[nw] = rep; nw++;
    push16(w[15:0]);
    push16(w[31:16]);
  endtask

  task automatic set_cfg(int f, int o, bit accept);
    @(negedge clk);
    cfg_we = 1; cfg_factor = FACTOR_W'(f); cfg_offset = OFS_W'(o);
    @(negedge clk);
    cfg_we = 0;
    if (accept) begin cur_f = f; cur_o = o; end
  endtask

  // words were added at the current falling edge
  task automatic play(string lbl);
    int p, reps, d, lp;
    bit bad;
    string tag;
    logic [47:0] seen;
    repeat (3) @(negedge clk);
    check(idle === 1'b1, {"R9 idle before start ", lbl}, 64'(idle), 64'd1);
    @(negedge clk);
    check(idle === 1'b0, {"R9 start latency ", lbl}, 64'(idle), 64'd0);
    for (int k = 0; k < nw; k++) begin
      p = wp[k];
      reps = (wr[k] == 0) ? 1 : wr[k];
      for (int r = 0; r < reps; r++) begin
        for (int s = 0; s <= lastix(p); s++) begin
          d = eff(p, s, cur_f, cur_o);
          bad = 0; seen = lvl(p, s);
          for (int c = 0; c < d; c++) begin
            if (clk_out !== lvl(p, s) || idle !== 1'b0) begin bad = 1; seen = clk_out; end
            @(negedge clk);
          end
          if (s == 0 && r == 0 && (wa[k] >= NPAT || wr[k] == 0 || wr[k] > 255)) tag = "R2";
          else if (s == 0 && r == 0 && k > 0) tag = "R7";
          else if (s == 0 && r > 0) tag = "R6";
          else if (tn(p, s)) tag = "R4";
          else tag = "R3";
          check(!bad, $sformatf("%s %s pat%0d rep%0d st%0d", tag, lbl, p, r, s), 64'(seen), 64'(lvl(p, s)));
        end
      end
    end
    lp = wp[nw - 1];
    check(idle === 1'b1 && clk_out === lvl(lp, lastix(lp)), {"R8 idle hold ", lbl},
          64'(clk_out), 64'(lvl(lp, lastix(lp))));
    repeat (5) @(negedge clk);
    check(idle === 1'b1 && clk_out === lvl(lp, lastix(lp)), {"R8 hold later ", lbl},
          64'(clk_out), 64'(lvl(lp, lastix(lp))));
    nw = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(clk_out === '0, "R1 clk_out reset", 64'(clk_out), 64'd0);
    check(idle === 1'b1, "R1 idle reset", 64'(idle), 64'd1);
    check(fifo_rd === 1'b0, "R1 fifo_rd reset", 64'(fifo_rd), 64'd0);
    for (int p = 0; p < NPAT; p++) begin
      for (int s = 0; s < NST; s++) begin
        st_we = 1; st_pat = PAT_AW'(p); st_idx = STATE_AW'(s);
        st_levels = lvl(p, s); st_dwell = DWELL_W'(dw(p, s)); st_tune = tn(p, s);
        @(negedge clk);
      end
      len_we = 1; len_pat = PAT_AW'(p); len_last = STATE_AW'(lastix(p));
      st_we = 0;
      @(negedge clk);
      len_we = 0;
    end
    // R1: factor 1 and offset 0 after reset, seen through the run below
    add_word(2, 2); add_word(8'h15, 1); add_word(0, 0); add_word(1, 257); add_word(8'h37, 1);
    play("R1 defaults");
    set_cfg(3, -2, 1);
    add_word(3, 1); add_word(4, 2); add_word(8'hFA, 1);
    play("f3 o-2");
    set_cfg(0, 50, 0);
    add_word(3, 1); add_word(6, 1);
    play("R5 zero factor rejected");
    set_cfg(2, -100, 1);
    add_word(9, 1); add_word(11, 2);
    play("R4 clamp");
    set_cfg(15, 127, 1);
    add_word(12, 1); add_word(13, 1);
    play("f15 o127");
    check(pop_viol == 0, "R10 pop while empty", 64'(pop_viol), 64'd0);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule